// File: doc/BRIEF.md
# Priority-level interrupt arbiter

This block sits between a group of up to eight peripheral devices and a processor core. It decides whether the core should be interrupted. A device asks for service when its ready flag and its interrupt-enable bit are both set. Each device has a fixed urgency level from 0 to 7, and 7 is the most urgent. The arbiter finds the most urgent pending device and compares its level with the priority level of the program that is running. It raises the interrupt only when the device's level is strictly higher.

The core checks for interrupts only between the store phase of one instruction and the fetch of the next. The block therefore registers its decision on a boundary strobe and holds it until the next strobe, so the core sees a stable value for the whole instruction. The latched device index and level tell the core which device won and at what urgency. The core keeps running normally when the flag is clear and enters the service routine when it is set.

Top module: `irq_prio_arbiter`

## Requirements
- R1: A device takes part in arbitration only when both its `dev_ready` bit and its `dev_ie` bit are 1. A device with only one of the two set is never reported and never raises `irq`.
- R2: Among the pending devices, the one with the numerically largest level is reported in `win_dev`, and its level is reported in `win_level`.
- R3: When several pending devices share the largest level, the device with the lowest index is reported.
- R4: `irq` is latched as 1 only if the reported level is strictly greater than `cur_pl` at the strobe. An equal or lower level latches `irq` as 0.
- R5: The outputs change only at a rising clock edge where `boundary` is 1. They hold their values at every other edge.
- R6: A strobe with no pending device latches `irq`=0, `win_level`=0 and `win_dev`=0.
- R7: While `rst_n` is 0, all outputs are 0 (asynchronous reset), and a strobe during reset has no effect.
- R8: Device i has the level held in bits [3i+2:3i] of parameter `DEV_LEVELS`. The default table gives devices 0 to 7 the levels 1, 4, 4, 2, 7, 0, 6, 4.
- R9: The winner's level and index are latched even when `irq` stays 0 because the winner's level does not exceed `cur_pl`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_ready | input | NUM_DEV | Ready flag per device |
| dev_ie | input | NUM_DEV | Interrupt-enable bit per device |
| cur_pl | input | LVL_W | Priority level of the running program |
| boundary | input | 1 | Instruction-boundary strobe that latches the decision |
| irq | output | 1 | Latched interrupt request to the core |
| win_level | output | LVL_W | Latched level of the winning device |
| win_dev | output | IDX_W | Latched index of the winning device |

## Verification
The properties assume that `dev_ready`, `dev_ie` and `cur_pl` are steady around each rising edge, because every property compares the latched outputs with the inputs seen at the previous strobe edge. They also assume that `boundary` is a plain synchronous level and that reset is released only while the inputs are quiet. The stimulus changes every input on the falling edge and raises `boundary` for a single cycle per decision. The one exception is a hold test, where the inputs move while `boundary` stays low to show that the outputs do not follow them.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

   // Selection network variants
   typedef enum int {
      SEL_LINEAR = 0,
      SEL_TREE   = 1
   } sel_style_e;

   localparam int PL_W_DEFAULT = 3;

   function automatic int idx_width(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/irq_req_gate.sv
module irq_req_gate #(
   parameter int NUM_DEV = 8
) (
   input  logic [NUM_DEV-1:0] dev_ready,
   input  logic [NUM_DEV-1:0] dev_ie,
   output logic [NUM_DEV-1:0] req
);

   // One qualifying AND per device
   for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
      assign req[g] = dev_ready[g] & dev_ie[g];
   end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
   import irq_arb_pkg::*;
#(
   parameter int                         NUM_DEV    = 8,
   parameter int                         LVL_W      = 3,
   parameter int                         IDX_W      = 3,
   parameter logic [NUM_DEV*LVL_W-1:0]   DEV_LEVELS = '0,
   parameter sel_style_e                 SEL_STYLE  = SEL_TREE
) (
   input  logic [NUM_DEV-1:0] req,
   output logic               any,
   output logic [LVL_W-1:0]   lvl,
   output logic [IDX_W-1:0]   idx
);

   localparam int NP    = 1 << IDX_W;
   localparam int NODES = 2 * NP - 1;

   if (SEL_STYLE == SEL_LINEAR) begin : g_linear
      // Ascending scan: strict compare keeps the lowest index on a tie
      always_comb begin
         logic             found;
         logic [LVL_W-1:0] best_l;
         logic [IDX_W-1:0] best_i;
         found  = 1'b0;
         best_l = '0;
         best_i = '0;
         for (int i = 0; i < NUM_DEV; i++) begin
            if (req[i] && (!found || (DEV_LEVELS[i*LVL_W +: LVL_W] > best_l))) begin
               found  = 1'b1;
               best_l = DEV_LEVELS[i*LVL_W +: LVL_W];
               best_i = IDX_W'(i);
            end
         end
         any = found;
         lvl = best_l;
         idx = best_i;
      end
   end else begin : g_tree
      // Balanced compare tree, leaves at NP-1 .. 2*NP-2
      logic             node_v [NODES];
      logic [LVL_W-1:0] node_l [NODES];
      logic [IDX_W-1:0] node_i [NODES];

      for (genvar g = 0; g < NP; g++) begin : g_leaf
         if (g < NUM_DEV) begin : g_real
            assign node_v[NP-1+g] = req[g];
            assign node_l[NP-1+g] = DEV_LEVELS[g*LVL_W +: LVL_W];
            assign node_i[NP-1+g] = IDX_W'(g);
         end else begin : g_pad
            assign node_v[NP-1+g] = 1'b0;
            assign node_l[NP-1+g] = '0;
            assign node_i[NP-1+g] = IDX_W'(g);
         end
      end

      for (genvar k = 0; k < NP - 1; k++) begin : g_node
         logic take_left;
         // left subtree holds lower indices, so it wins on equal level
         assign take_left = node_v[2*k+1] &&
                            (!node_v[2*k+2] || (node_l[2*k+1] >= node_l[2*k+2]));
         assign node_v[k] = node_v[2*k+1] | node_v[2*k+2];
         assign node_l[k] = take_left ? node_l[2*k+1] : node_l[2*k+2];
         assign node_i[k] = take_left ? node_i[2*k+1] : node_i[2*k+2];
      end

      assign any = node_v[0];
      assign lvl = node_v[0] ? node_l[0] : '0;
      assign idx = node_v[0] ? node_i[0] : '0;
   end

endmodule

// File: rtl/irq_bnd_latch.sv
module irq_bnd_latch #(
   parameter int LVL_W = 3,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             boundary,
   input  logic             any,
   input  logic [LVL_W-1:0] lvl,
   input  logic [IDX_W-1:0] idx,
   input  logic [LVL_W-1:0] cur_pl,
   output logic             irq,
   output logic [LVL_W-1:0] win_level,
   output logic [IDX_W-1:0] win_dev
);

   logic above;

   // Strictly above: an equal level never preempts
   assign above = any && (lvl > cur_pl);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq       <= 1'b0;
         win_level <= '0;
         win_dev   <= '0;
      end else if (boundary) begin
         irq       <= above;
         win_level <= any ? lvl : '0;
         win_dev   <= any ? idx : '0;
      end
   end

endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
   import irq_arb_pkg::*;
#(
   parameter int                       NUM_DEV    = 8,
   parameter int                       LVL_W      = PL_W_DEFAULT,
   parameter logic [NUM_DEV*LVL_W-1:0] DEV_LEVELS = 24'h987521,
   parameter sel_style_e               SEL_STYLE  = SEL_TREE,
   localparam int                      IDX_W      = idx_width(NUM_DEV)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_DEV-1:0] dev_ready,
   input  logic [NUM_DEV-1:0] dev_ie,
   input  logic [LVL_W-1:0]   cur_pl,
   input  logic               boundary,
   output logic               irq,
   output logic [LVL_W-1:0]   win_level,
   output logic [IDX_W-1:0]   win_dev
);

   // Elaboration-time parameter checks
   if (NUM_DEV < 2 || NUM_DEV > 64) begin : g_bad_num
      $error("irq_prio_arbiter: NUM_DEV must lie in 2..64");
   end
   if (LVL_W < 1 || LVL_W > 8) begin : g_bad_lvl
      $error("irq_prio_arbiter: LVL_W must lie in 1..8");
   end
   if (SEL_STYLE != SEL_LINEAR && SEL_STYLE != SEL_TREE) begin : g_bad_sel
      $error("irq_prio_arbiter: unknown SEL_STYLE");
   end

   logic [NUM_DEV-1:0] req;
   logic               pick_any;
   logic [LVL_W-1:0]   pick_lvl;
   logic [IDX_W-1:0]   pick_idx;

   irq_req_gate #(
      .NUM_DEV (NUM_DEV)
   ) u_gate (
      .dev_ready (dev_ready),
      .dev_ie    (dev_ie),
      .req       (req)
   );

   irq_prio_pick #(
      .NUM_DEV    (NUM_DEV),
      .LVL_W      (LVL_W),
      .IDX_W      (IDX_W),
      .DEV_LEVELS (DEV_LEVELS),
      .SEL_STYLE  (SEL_STYLE)
   ) u_pick (
      .req (req),
      .any (pick_any),
      .lvl (pick_lvl),
      .idx (pick_idx)
   );

   irq_bnd_latch #(
      .LVL_W (LVL_W),
      .IDX_W (IDX_W)
   ) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .boundary  (boundary),
      .any       (pick_any),
      .lvl       (pick_lvl),
      .idx       (pick_idx),
      .cur_pl    (cur_pl),
      .irq       (irq),
      .win_level (win_level),
      .win_dev   (win_dev)
   );

endmodule

// File: rtl/irq_prio_arbiter_chk.sv
module irq_prio_arbiter_chk #(
   parameter int                       NUM_DEV    = 8,
   parameter int                       LVL_W      = 3,
   parameter logic [NUM_DEV*LVL_W-1:0] DEV_LEVELS = '0,
   parameter int                       IDX_W      = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_DEV-1:0] dev_ready,
   input logic [NUM_DEV-1:0] dev_ie,
   input logic [LVL_W-1:0]   cur_pl,
   input logic               boundary,
   input logic               irq,
   input logic [LVL_W-1:0]   win_level,
   input logic [IDX_W-1:0]   win_dev
);

   logic [NUM_DEV-1:0] req_v;
   logic [NUM_DEV-1:0] req_q;
   logic [LVL_W-1:0]   pl_q;

   assign req_v = dev_ready & dev_ie;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= '0;
         pl_q  <= '0;
      end else begin
         req_q <= req_v;
         pl_q  <= cur_pl;
      end
   end

   function automatic logic [LVL_W-1:0] level_of(input int i);
      return LVL_W'(DEV_LEVELS >> (i * LVL_W));
   endfunction

   // Some pending device ranks above the reported one
   function automatic logic outranked(input logic [NUM_DEV-1:0] r,
                                      input logic [IDX_W-1:0]   w,
                                      input logic [LVL_W-1:0]   l);
      logic hit;
      hit = 1'b0;
      for (int j = 0; j < NUM_DEV; j++) begin
         if (r[j] && ((level_of(j) > l) || ((level_of(j) == l) && (j < int'(w)))))
            hit = 1'b1;
      end
      return hit;
   endfunction

   assert_hold_outputs_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !boundary |=> ($stable(irq) && $stable(win_level) && $stable(win_dev)));

   assert_strictly_above_R4: assert property (@(posedge clk) disable iff (!rst_n)
      boundary |=> (!irq || (win_level > pl_q)));

   assert_winner_pending_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && (req_v != '0)) |=> req_q[win_dev]);

   assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && (req_v == '0)) |=> (!irq && (win_level == '0) && (win_dev == '0)));

   assert_level_table_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && (req_v != '0)) |=> (win_level == level_of(int'(win_dev))));

   // Covers R2 (highest level) and the lowest-index tie rule
   assert_top_choice_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && (req_v != '0)) |=> !outranked(req_q, win_dev, win_level));

endmodule

bind irq_prio_arbiter irq_prio_arbiter_chk #(
   .NUM_DEV    (NUM_DEV),
   .LVL_W      (LVL_W),
   .DEV_LEVELS (DEV_LEVELS),
   .IDX_W      (IDX_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .dev_ready (dev_ready),
   .dev_ie    (dev_ie),
   .cur_pl    (cur_pl),
   .boundary  (boundary),
   .irq       (irq),
   .win_level (win_level),
   .win_dev   (win_dev)
);

// File: tb/tb_irq_prio_arbiter.sv
module tb_irq_prio_arbiter;

   logic       clk;
   logic       rst_n;
   logic [7:0] dev_ready;
   logic [7:0] dev_ie;
   logic [2:0] cur_pl;
   logic       boundary;
   logic       irq;
   logic [2:0] win_level;
   logic [2:0] win_dev;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 0;

   irq_prio_arbiter dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .dev_ready (dev_ready),
      .dev_ie    (dev_ie),
      .cur_pl    (cur_pl),
      .boundary  (boundary),
      .irq       (irq),
      .win_level (win_level),
      .win_dev   (win_dev)
   );

   initial clk = 1'b0;
   always #2 clk = ~clk;

   // {ready, ie, cur_pl, exp_irq, exp_level, exp_dev}
   // device levels 0..7 = 1,4,4,2,7,0,6,4
   localparam int NV = 14;
   localparam logic [25:0] VECS [NV] = '{
      {8'hFF, 8'h00, 3'd0, 1'b0, 3'd0, 3'd0},   // R1 none enabled, R6
      {8'h01, 8'h01, 3'd0, 1'b1, 3'd1, 3'd0},   // R4 1 > 0
      {8'h01, 8'h01, 3'd1, 1'b0, 3'd1, 3'd0},   // R4 equal, R9
      {8'hFF, 8'hFF, 3'd3, 1'b1, 3'd7, 3'd4},   // R2 all pending
      {8'h06, 8'h06, 3'd0, 1'b1, 3'd4, 3'd1},   // R3 tie 1 vs 2
      {8'h86, 8'h84, 3'd3, 1'b1, 3'd4, 3'd2},   // R3 tie 2 vs 7, R1
      {8'h48, 8'h48, 3'd6, 1'b0, 3'd6, 3'd6},   // R4 equal, R9
      {8'h48, 8'h48, 3'd5, 1'b1, 3'd6, 3'd6},   // R2 R4
      {8'h20, 8'h20, 3'd0, 1'b0, 3'd0, 3'd5},   // R8 level 0 device
      {8'h10, 8'h00, 3'd0, 1'b0, 3'd0, 3'd0},   // R1 ready only
      {8'h00, 8'h10, 3'd0, 1'b0, 3'd0, 3'd0},   // R1 enable only
      {8'h10, 8'h10, 3'd7, 1'b0, 3'd7, 3'd4},   // R4 top level equal
      {8'h10, 8'h10, 3'd6, 1'b1, 3'd7, 3'd4},   // R4
      {8'h8B, 8'hFF, 3'd2, 1'b1, 3'd4, 3'd1}    // R2 R3 mixed
   };

   task automatic check(input string tag, input logic ei,
                        input logic [2:0] el, input logic [2:0] ed);
      n_chk++;
      if (irq !== ei || win_level !== el || win_dev !== ed) begin
         n_fail++;
         $display("FAIL %s: got irq=%0b level=%0d dev=%0d, expected irq=%0b level=%0d dev=%0d",
                  tag, irq, win_level, win_dev, ei, el, ed);
      end
   endtask

   task automatic strobe(input logic [7:0] r, input logic [7:0] e, input logic [2:0] p);
      dev_ready = r;
      dev_ie    = e;
      cur_pl    = p;
      boundary  = 1'b1;
      @(negedge clk);
      boundary  = 1'b0;
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      rst_n     = 1'b0;
      dev_ready = '0;
      dev_ie    = '0;
      cur_pl    = '0;
      boundary  = 1'b0;
      repeat (3) @(negedge clk);
      check("R7 during reset", 1'b0, 3'd0, 3'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R7 after release", 1'b0, 3'd0, 3'd0);

      // Table walk: R1 R2 R3 R4 R6 R8 R9
      for (int v = 0; v < NV; v++) begin
         strobe(VECS[v][25:18], VECS[v][17:10], VECS[v][9:7]);
         check($sformatf("vector %0d (R1 R2 R3 R4 R6 R8 R9)", v),
               VECS[v][6], VECS[v][5:3], VECS[v][2:0]);
      end

      // R5: inputs move without a strobe, outputs hold
      dev_ready = 8'hFF;
      dev_ie    = 8'hFF;
      cur_pl    = 3'd0;
      repeat (3) @(negedge clk);
      check("R5 hold without strobe", 1'b1, 3'd4, 3'd1);
      strobe(8'hFF, 8'hFF, 3'd0);
      check("R5 strobe updates", 1'b1, 3'd7, 3'd4);
      dev_ready = 8'h00;
      @(negedge clk);
      check("R5 hold after clear", 1'b1, 3'd7, 3'd4);

      // R6: strobe with nothing pending clears
      strobe(8'h00, 8'hFF, 3'd0);
      check("R6 idle strobe", 1'b0, 3'd0, 3'd0);

      // R9 then R7 mid-run reset
      strobe(8'h20, 8'h20, 3'd7);
      check("R9 latched without irq", 1'b0, 3'd0, 3'd5);
      strobe(8'h40, 8'h40, 3'd2);
      check("R4 before reset", 1'b1, 3'd6, 3'd6);
      rst_n = 1'b0;
      #1;
      check("R7 async clear", 1'b0, 3'd0, 3'd0);
      @(negedge clk);
      strobe(8'hFF, 8'hFF, 3'd0);
      check("R7 strobe ignored in reset", 1'b0, 3'd0, 3'd0);
      dev_ready = '0;
      dev_ie    = '0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R7 quiet after release", 1'b0, 3'd0, 3'd0);

      done = 1;
      summary();
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         summary();
         $finish;
      end
   end

endmodule